// File: doc/BRIEF.md
# Indirect Transmit Block-Pointer Access Controller

This block sits between a host register bus and a small table of per-channel transmit-buffer starting block pointers. There are 40 channels and each has a 9-bit pointer that names one of 512 buffer blocks. The host never addresses the table directly. It loads a 9-bit value into a data register, then writes a select register that carries a channel number and a direction bit. Writing the select register launches exactly one table read or one table write. A busy flag in the select register tells the host when the access has finished and, for a read, when the fetched pointer is sitting in the data register.

The table is a single-port RAM that is shared with the transmit engine. The engine reads and updates the live pointer of a channel through its own port, and that port always wins the RAM. A pending host access therefore waits, with busy held high, for a cycle in which the engine is idle. Because of this, a value read back by the host is the pointer the engine is using at that moment, which is not necessarily what the host last wrote. Channel numbers beyond the last channel finish without touching the table, and a read of such a channel returns zero.

Top module: `txptr_indirect_ctrl`

## Requirements
- R1: After reset, a read of the select register (offset 0x980) returns 0x0000, so busy is 0, and a read of the data register (offset 0x984) returns 0x0000.
- R2: In the select register, bits 5:0 hold the channel number (0x00 is the first channel, 0x27 is the 40th), bit 14 holds the direction (1 = read, 0 = write) and bit 15 is a read-only busy flag. Bits 13:6 read as 0 whatever was written to them.
- R3: The data register holds the pointer in bits 8:0. Bits 15:9 read as 0.
- R4: Writing the select register with bit 14 = 0 copies the data register into the table entry of the selected channel. Busy then clears once that entry holds the value.
- R5: Writing the select register with bit 14 = 1 loads the selected channel's entry into the data register. Busy stays 1 until the data register holds that value.
- R6: Busy reads 1 from the first clock edge after the select write. It stays 1 for at least two clock edges, so it reads 1 when sampled after the first and the second edge.
- R7: While the engine request is high, a pending host access is not granted the RAM and busy stays 1. The access completes after the engine releases the RAM.
- R8: An engine read returns the entry of its channel on eng_rdata one clock edge after the request edge. An engine write updates the entry, and a later host read returns the engine's value.
- R9: While busy is 1, writes to the select register and to the data register are ignored. The channel and direction of the access in flight, and the value it writes, are unchanged.
- R10: A channel number above 0x27 completes the access without any RAM access and without changing any table entry. A read of such a channel loads 0 into the data register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_addr | input | 12 | Host register offset (0x980 select, 0x984 data) |
| hst_wr | input | 1 | Host write strobe, one cycle per write |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data for hst_addr (combinational) |
| eng_req | input | 1 | Engine RAM request (has priority) |
| eng_we | input | 1 | Engine request is a write when 1 |
| eng_ch | input | 6 | Engine channel number |
| eng_wdata | input | 9 | Engine pointer to write |
| eng_rdata | output | 9 | Engine read result, one edge after the request |

## Verification
A select write is captured on the edge after it is driven, and busy is visible from that edge. With the engine idle, the RAM is granted on the next edge and busy clears on the edge after that. A stalled access stretches this by one edge per cycle of engine request. So, apart from the R6 check, which samples busy after exactly the first and second edges, the bench polls busy on falling edges and reads the data register only after busy has cleared. Engine read results are due one edge after the request and are sampled on the falling edge that follows. Every expected value is queued from the requirement-level model before the matching read is made.

// File: rtl/txptr_pkg.sv
package txptr_pkg;

    localparam int CH_W    = 6;
    localparam int NUM_CH  = 40;
    localparam int PTR_W   = 9;
    localparam int REG_W   = 16;
    localparam int ADDR_W  = 12;

    localparam logic [ADDR_W-1:0] SEL_OFS = 12'h980;
    localparam logic [ADDR_W-1:0] DAT_OFS = 12'h984;

    localparam int BUSY_BIT = 15;
    localparam int DIR_BIT  = 14;

    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_WAIT   = 2'd1,
        ACC_FINISH = 2'd2
    } acc_state_e;

    typedef struct packed {
        logic             en;
        logic             we;
        logic [CH_W-1:0]  ch;
        logic [PTR_W-1:0] wdata;
    } ram_cmd_t;

    function automatic logic ch_in_range(input logic [CH_W-1:0] ch);
        return (int'(ch) < NUM_CH);
    endfunction

    function automatic logic [REG_W-1:0] pack_sel(input logic busy,
                                                  input logic dir,
                                                  input logic [CH_W-1:0] ch);
        logic [REG_W-1:0] v;
        v = '0;
        v[CH_W-1:0] = ch;
        v[DIR_BIT]  = dir;
        v[BUSY_BIT] = busy;
        return v;
    endfunction

    function automatic logic [REG_W-1:0] pack_dat(input logic [PTR_W-1:0] p);
        logic [REG_W-1:0] v;
        v = '0;
        v[PTR_W-1:0] = p;
        return v;
    endfunction

endpackage

// File: rtl/txptr_ram.sv
module txptr_ram
    import txptr_pkg::*;
(
    input  logic             clk,
    input  ram_cmd_t         cmd,
    output logic [PTR_W-1:0] rdata
);
    logic [PTR_W-1:0] mem [NUM_CH];
    logic             hit;

    assign hit = ch_in_range(cmd.ch);

    always_ff @(posedge clk) begin
        if (cmd.en && cmd.we && hit) begin
            mem[cmd.ch] <= cmd.wdata;
        end
        if (cmd.en && !cmd.we) begin
            rdata <= hit ? mem[cmd.ch] : '0;
        end
    end

endmodule

// File: rtl/txptr_arb.sv
module txptr_arb
    import txptr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ram_cmd_t eng_cmd,
    input  ram_cmd_t host_cmd,
    output logic     host_gnt,
    output ram_cmd_t ram_cmd
);
    assign host_gnt = host_cmd.en && !eng_cmd.en;
    assign ram_cmd  = eng_cmd.en ? eng_cmd : (host_gnt ? host_cmd : '0);

    // R7
    eng_priority_chk: assert property (@(posedge clk) disable iff (rst)
        eng_cmd.en |-> !host_gnt);

    // R7
    host_served_chk: assert property (@(posedge clk) disable iff (rst)
        (host_cmd.en && !eng_cmd.en) |-> (ram_cmd.ch == host_cmd.ch && ram_cmd.en));

    // R10
    host_range_chk: assert property (@(posedge clk) disable iff (rst)
        host_cmd.en |-> ch_in_range(host_cmd.ch));

endmodule

// File: rtl/txptr_host_regs.sv
module txptr_host_regs
    import txptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output ram_cmd_t          host_cmd,
    input  logic              host_gnt,
    input  logic [PTR_W-1:0]  ram_rdata
);
    acc_state_e       state_q;
    logic [CH_W-1:0]  ch_q;
    logic             dir_q;
    logic [PTR_W-1:0] data_q;
    logic             busy;
    logic             sel_wr;
    logic             dat_wr;
    logic             ch_ok;

    assign busy   = (state_q != ACC_IDLE);
    assign sel_wr = wr && (addr == SEL_OFS);
    assign dat_wr = wr && (addr == DAT_OFS);
    assign ch_ok  = ch_in_range(ch_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ACC_IDLE;
            ch_q    <= '0;
            dir_q   <= 1'b0;
            data_q  <= '0;
        end else begin
            case (state_q)
                ACC_IDLE: begin
                    if (sel_wr) begin
                        ch_q    <= wdata[CH_W-1:0];
                        dir_q   <= wdata[DIR_BIT];
                        state_q <= ACC_WAIT;
                    end else if (dat_wr) begin
                        data_q <= wdata[PTR_W-1:0];
                    end
                end
                ACC_WAIT: begin
                    if (!ch_ok || host_gnt) begin
                        state_q <= ACC_FINISH;
                    end
                end
                ACC_FINISH: begin
                    if (dir_q) begin
                        data_q <= ch_ok ? ram_rdata : '0;
                    end
                    state_q <= ACC_IDLE;
                end
                default: state_q <= ACC_IDLE;
            endcase
        end
    end

    always_comb begin
        host_cmd.en    = (state_q == ACC_WAIT) && ch_ok;
        host_cmd.we    = !dir_q;
        host_cmd.ch    = ch_q;
        host_cmd.wdata = data_q;
    end

    always_comb begin
        if (addr == SEL_OFS) begin
            rdata = pack_sel(busy, dir_q, ch_q);
        end else if (addr == DAT_OFS) begin
            rdata = pack_dat(data_q);
        end else begin
            rdata = '0;
        end
    end

    // R6
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && sel_wr) |=> busy);

    // R6
    min_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && sel_wr) |=> ##1 busy);

    // R9
    hold_data_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ACC_WAIT) |=> $stable(data_q));

    // R9
    hold_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && sel_wr) |=> ($stable(ch_q) && $stable(dir_q)));

    // R5
    read_done_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ACC_FINISH) |=> !busy);

endmodule

// File: rtl/txptr_indirect_ctrl.sv
module txptr_indirect_ctrl
    import txptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic              hst_wr,
    input  logic [REG_W-1:0]  hst_wdata,
    output logic [REG_W-1:0]  hst_rdata,
    input  logic              eng_req,
    input  logic              eng_we,
    input  logic [CH_W-1:0]   eng_ch,
    input  logic [PTR_W-1:0]  eng_wdata,
    output logic [PTR_W-1:0]  eng_rdata
);
    ram_cmd_t         eng_cmd;
    ram_cmd_t         host_cmd;
    ram_cmd_t         ram_cmd;
    logic             host_gnt;
    logic [PTR_W-1:0] ram_rdata;

    always_comb begin
        eng_cmd.en    = eng_req;
        eng_cmd.we    = eng_we;
        eng_cmd.ch    = eng_ch;
        eng_cmd.wdata = eng_wdata;
    end

    txptr_host_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (hst_addr),
        .wr        (hst_wr),
        .wdata     (hst_wdata),
        .rdata     (hst_rdata),
        .host_cmd  (host_cmd),
        .host_gnt  (host_gnt),
        .ram_rdata (ram_rdata)
    );

    txptr_arb u_arb (
        .clk      (clk),
        .rst      (rst),
        .eng_cmd  (eng_cmd),
        .host_cmd (host_cmd),
        .host_gnt (host_gnt),
        .ram_cmd  (ram_cmd)
    );

    txptr_ram u_ram (
        .clk   (clk),
        .cmd   (ram_cmd),
        .rdata (ram_rdata)
    );

    assign eng_rdata = ram_rdata;

endmodule

// File: tb/txptr_indirect_ctrl_tb.sv
module txptr_indirect_ctrl_tb;
    import txptr_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] hst_addr = '0;
    logic              hst_wr = 1'b0;
    logic [REG_W-1:0]  hst_wdata = '0;
    logic [REG_W-1:0]  hst_rdata;
    logic              eng_req = 1'b0;
    logic              eng_we = 1'b0;
    logic [CH_W-1:0]   eng_ch = '0;
    logic [PTR_W-1:0]  eng_wdata = '0;
    logic [PTR_W-1:0]  eng_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } exp_t;
    exp_t        sb_q[$];
    logic [15:0] mon_val;
    event        mon_ev;

    always #5 clk = ~clk;

    txptr_indirect_ctrl u_dut (
        .clk(clk), .rst(rst), .hst_addr(hst_addr), .hst_wr(hst_wr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .eng_req(eng_req),
        .eng_we(eng_we), .eng_ch(eng_ch), .eng_wdata(eng_wdata),
        .eng_rdata(eng_rdata)
    );

    function automatic logic [8:0] pat(input int i);
        return 9'((i * 13 + 5) & 511);
    endfunction

    // monitor: pops the next expected item and compares
    initial begin
        forever begin
            @(mon_ev);
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected result: actual %h expected none", mon_val);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (mon_val !== e.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", e.tag, mon_val, e.exp);
                end
            end
        end
    end

    task automatic observe(input logic [15:0] v, input logic [15:0] exp, input string tag);
        sb_q.push_back('{exp: exp, tag: tag});
        mon_val = v;
        -> mon_ev;
        #1;
    endtask

    task automatic reg_read(input logic [ADDR_W-1:0] a, output logic [15:0] v);
        hst_addr = a;
        #1;
        v = hst_rdata;
    endtask

    task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [15:0] v);
        @(negedge clk);
        hst_addr = a; hst_wdata = v; hst_wr = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int k = 0; k < 1000; k++) begin
            reg_read(SEL_OFS, v);
            if (!v[15]) return;
            @(negedge clk);
        end
        errors++;
        $display("FAIL busy never cleared: actual 1 expected 0");
    endtask

    task automatic host_put(input logic [5:0] ch, input logic [8:0] p);
        reg_write(DAT_OFS, {7'd0, p});
        reg_write(SEL_OFS, {2'b00, 8'd0, ch});
        wait_idle();
    endtask

    task automatic host_get(input logic [5:0] ch, output logic [15:0] v);
        reg_write(SEL_OFS, {2'b01, 8'd0, ch});
        wait_idle();
        reg_read(DAT_OFS, v);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_read(SEL_OFS, v); observe(v, 16'h0000, "R1 select after reset");
        reg_read(DAT_OFS, v); observe(v, 16'h0000, "R1 data after reset");

        // R3 reserved data bits read 0
        reg_write(DAT_OFS, 16'hFFFF);
        reg_read(DAT_OFS, v); observe(v, 16'h01FF, "R3 data reserved bits");

        // R4 initialise every entry through host writes
        for (int i = 0; i < NUM_CH; i++) host_put(6'(i), pat(i));

        // R2 select fields after a write command with reserved bits set
        reg_write(DAT_OFS, {7'd0, pat(39)});
        reg_write(SEL_OFS, 16'h3FE7);
        wait_idle();
        reg_read(SEL_OFS, v); observe(v, 16'h0027, "R2 select fields, reserved 0");

        // R5 read back every entry
        for (int i = 0; i < NUM_CH; i++) begin
            host_get(6'(i), v);
            observe(v, {7'd0, pat(i)}, "R5 R4 read-back");
        end
        reg_read(SEL_OFS, v); observe(v, 16'h4027, "R2 select read dir");

        // R6 busy visible after first and second edge
        reg_write(SEL_OFS, {2'b01, 8'd0, 6'd4});
        reg_read(SEL_OFS, v); observe({15'd0, v[15]}, 16'd1, "R6 busy after edge 1");
        @(negedge clk);
        reg_read(SEL_OFS, v); observe({15'd0, v[15]}, 16'd1, "R6 busy after edge 2");
        wait_idle();
        reg_read(DAT_OFS, v); observe(v, {7'd0, pat(4)}, "R6 R5 data after busy");

        // R8 engine read
        @(negedge clk);
        eng_req = 1'b1; eng_we = 1'b0; eng_ch = 6'd2;
        @(negedge clk);
        eng_req = 1'b0;
        observe({7'd0, eng_rdata}, {7'd0, pat(2)}, "R8 engine read");

        // R8 engine write seen by host read
        @(negedge clk);
        eng_req = 1'b1; eng_we = 1'b1; eng_ch = 6'd7; eng_wdata = 9'h1AB;
        @(negedge clk);
        eng_req = 1'b0; eng_we = 1'b0;
        host_get(6'd7, v); observe(v, 16'h01AB, "R8 live pointer via host");

        // R7 engine holds the RAM, host waits
        @(negedge clk);
        eng_req = 1'b1; eng_we = 1'b0; eng_ch = 6'd1;
        reg_write(DAT_OFS, 16'h0155);
        reg_write(SEL_OFS, {2'b00, 8'd0, 6'd3});
        repeat (6) @(negedge clk);
        reg_read(SEL_OFS, v); observe({15'd0, v[15]}, 16'd1, "R7 busy while engine active");

        // R9 writes during busy ignored
        reg_write(DAT_OFS, 16'h00AA);
        reg_write(SEL_OFS, {2'b01, 8'd0, 6'd5});
        reg_read(SEL_OFS, v); observe(v, 16'h8003, "R9 R7 select unchanged while busy");
        eng_req = 1'b0;
        wait_idle();
        reg_read(DAT_OFS, v); observe(v, 16'h0155, "R9 data unchanged");
        host_get(6'd3, v); observe(v, 16'h0155, "R7 R9 stalled write landed");
        host_get(6'd5, v); observe(v, {7'd0, pat(5)}, "R9 ignored select left ch5");

        // R10 out-of-range channel
        host_put(6'h30, 9'h0EE);
        reg_read(SEL_OFS, v); observe(v, 16'h0030, "R10 out-of-range write completes");
        host_get(6'h30, v); observe(v, 16'h0000, "R10 out-of-range read gives 0");
        host_get(6'd0, v); observe(v, {7'd0, pat(0)}, "R10 entry 0 untouched");
        host_get(6'd8, v); observe(v, {7'd0, pat(8)}, "R10 entry 8 untouched");

        #1;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule